// File: doc/BRIEF.md
# Root Hub Port Status and Control Bank

This block keeps the root hub state of a two-port USB host controller. It holds one hub-wide status word and one 32-bit word per downstream port. The low half of each port word shows the live state of the port. The high half holds sticky change flags that hardware sets and software clears. A simple command bus carries an 8-bit command code: bit 7 set means a write, bit 7 clear means a read. The port logic supplies connect, low-speed and overcurrent levels. The host engine supplies a busy flag that stays high for the whole of a token-to-handshake transaction.

Writes that touch a port word are not applied at once. Each port keeps one pending request slot. A write is merged into that slot and applied on the first cycle in which the transaction engine is idle. In this way software can never change the state of a port in the middle of a transaction. A hub-wide command turns off port power. In global mode it acts on all ports. In per-port mode it acts only on ports that are not marked as individually controlled. The bank drives power, enable, suspend and reset levels back to the port logic, each straight from a register.

Top module: `rh_port_bank`

## Requirements
- R1: After reset, every readable word reads 0 and the outputs port_power, port_enable, port_suspend and port_reset are all 0.
- R2: A read command is 0x14 for the hub word, 0x15 for port 0 and 0x16 for port 1. The matching write codes are 0x94, 0x95 and 0x96. Read data appears on rdata in the cycle after the command. In a port word the status bits are: connected at bit 0, enabled at bit 1, suspended at bit 2, port overcurrent at bit 3, in reset at bit 4, powered at bit 8 and low-speed at bit 9. The change flags sit 16 places higher: connect change at bit 16, enable change at bit 17, suspend change at bit 18, overcurrent change at bit 19 and reset done at bit 20.
- R3: Bit 0 follows the connect input. Any change of that input sets bit 16. Bit 9 reads 1 only while the port is both connected and low-speed.
- R4: Writing 1 to a change flag in bits 20:16 clears it. Writing 0 leaves it as it is. A new event in the same cycle takes priority over the clear.
- R5: In a port write, a 1 in one of the low bits is a request. Bit 1 requests enable and needs the port to be connected. Bit 2 requests suspend and needs the port to be enabled and not in reset. Bit 4 requests a port reset and needs the port to be connected. Bit 8 requests power. A write of 0 changes nothing.
- R6: A port reset clears suspend, and if the port was suspended it sets bit 18. The reset lasts RST_CYCLES cycles. At the end, bit 4 clears, bit 20 sets and the port becomes enabled.
- R7: While xfer_busy is high, a port write is held back. It takes effect on the first clock edge at which xfer_busy is low.
- R8: Several port writes that arrive while a transaction is running are merged by OR into one pending request, and all of them are applied together.
- R9: Bit 0 of the hub word always reads 0. When pwr_per_port is 0, writing 1 to bit 0 at code 0x94 removes power from every port at the edge on which the command is taken.
- R10: When pwr_per_port is 1, the same hub write removes power only from ports whose ppc_mask bit is 0. Writing 0 to hub bit 0 does nothing.
- R11: Hub bit 1 shows oc_global while oc_per_port is 0, and reads 0 while oc_per_port is 1. In per-port mode, port bit 3 follows the port's overcurrent input, and a rising edge on that input sets bit 19.
- R12: When a port disconnects, it leaves the enabled and suspended states at once. If it was enabled, bit 17 sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code; bit 7 set means write |
| cmd_wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| xfer_busy | input | 1 | High while a bus transaction is in progress |
| pwr_per_port | input | 1 | 0 selects global power mode, 1 selects per-port power mode |
| ppc_mask | input | NPORTS | Per-port power-control mask |
| oc_per_port | input | 1 | 1 selects per-port overcurrent reporting |
| oc_global | input | 1 | Global overcurrent level |
| conn_i | input | NPORTS | Per-port device-connected level |
| ls_i | input | NPORTS | Per-port low-speed device level |
| oc_i | input | NPORTS | Per-port overcurrent level |
| port_power | output | NPORTS | Port power on |
| port_enable | output | NPORTS | Port enabled |
| port_suspend | output | NPORTS | Port suspended |
| port_reset | output | NPORTS | Port reset in progress |

## Verification
The hardest case to reach from the ports is the merging of several writes that are held back during one transaction. To reach it, the bench raises xfer_busy and then issues a power request and an enable request to the same port. Before releasing the busy flag, it confirms that neither request has taken effect. If only the newest pending write were kept, power would stay off, so the bench detects a lost merge. A second hard case is the end of a port reset on a suspended port. To reach it, the bench drives the port through connect, enable and suspend, and only then asks for a reset.

// File: rtl/rh_pkg.sv
package rh_pkg;
  localparam int CODE_W = 8;
  localparam int DATA_W = 32;
  localparam int HALF_W = DATA_W / 2;
  localparam logic [CODE_W-1:0] RD_HUB = 8'h14;
  localparam logic [CODE_W-1:0] WR_HUB = 8'h94;
  // status bit positions in a port word (decoded by software)
  localparam int B_CCS  = 0;
  localparam int B_PES  = 1;
  localparam int B_PSS  = 2;
  localparam int B_POCI = 3;
  localparam int B_PRS  = 4;
  localparam int B_PPS  = 8;
  localparam int B_LSDA = 9;
  // change flags sit HALF_W above their status bit
  localparam int C_CSC  = 0;
  localparam int C_PESC = 1;
  localparam int C_PSSC = 2;
  localparam int C_OCIC = 3;
  localparam int C_PRSC = 4;
  localparam int NCHG   = 5;
endpackage

// File: rtl/rh_wr_defer.sv
module rh_wr_defer
  import rh_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  output logic              apply_o,
  output logic [HALF_W-1:0] pset_o,
  output logic [HALF_W-1:0] pclr_o
);
  logic              pend_q;
  logic [HALF_W-1:0] set_q, clr_q;

  assign apply_o = pend_q && !busy_i;
  assign pset_o  = set_q;
  assign pclr_o  = clr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      set_q  <= '0;
      clr_q  <= '0;
    end else if (wr_en_i) begin
      pend_q <= 1'b1;
      set_q  <= (apply_o ? '0 : set_q) | wdata_i[HALF_W-1:0];
      clr_q  <= (apply_o ? '0 : clr_q) | wdata_i[DATA_W-1:HALF_W];
    end else if (apply_o) begin
      pend_q <= 1'b0;
      set_q  <= '0;
      clr_q  <= '0;
    end
  end
endmodule

// File: rtl/rh_port_ch.sv
module rh_port_ch
  import rh_pkg::*;
#(
  parameter int RST_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              clr_pwr_i,
  input  logic              oc_pp_mode_i,
  input  logic              conn_i,
  input  logic              ls_i,
  input  logic              oc_i,
  output logic [DATA_W-1:0] word_o,
  output logic              pes_o,
  output logic              pss_o,
  output logic              prs_o,
  output logic              pps_o
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic              apply;
  logic [HALF_W-1:0] pset, pclr;
  logic ccs_q, pes_q, pss_q, poci_q, prs_q, pps_q, lsda_q;
  logic [NCHG-1:0] chg_q, chg_set, chg_clr;
  logic [CNT_W-1:0] cnt_q;
  logic req_pes, req_pss, req_prs, req_pps, rst_done, oc_now;

  rh_wr_defer u_defer (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wdata_i(wdata_i), .busy_i(busy_i),
    .apply_o(apply), .pset_o(pset), .pclr_o(pclr)
  );

  always_comb begin
    req_pes  = apply && pset[B_PES] && ccs_q;
    req_pss  = apply && pset[B_PSS] && pes_q && !prs_q;
    req_prs  = apply && pset[B_PRS] && ccs_q && !prs_q;
    req_pps  = apply && pset[B_PPS];
    rst_done = prs_q && (cnt_q == CNT_W'(RST_CYCLES - 1));
    oc_now   = oc_pp_mode_i && oc_i;
    chg_clr  = apply ? pclr[NCHG-1:0] : '0;
    chg_set          = '0;
    chg_set[C_CSC]   = conn_i != ccs_q;
    chg_set[C_PESC]  = pes_q && !conn_i;
    chg_set[C_PSSC]  = pss_q && req_prs;
    chg_set[C_OCIC]  = oc_now && !poci_q;
    chg_set[C_PRSC]  = rst_done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ccs_q <= 1'b0; pes_q <= 1'b0; pss_q <= 1'b0; poci_q <= 1'b0;
      prs_q <= 1'b0; pps_q <= 1'b0; lsda_q <= 1'b0;
      chg_q <= '0;   cnt_q <= '0;
    end else begin
      ccs_q  <= conn_i;
      lsda_q <= conn_i && ls_i;
      poci_q <= oc_now;
      chg_q  <= chg_set | (chg_q & ~chg_clr);
      if (!conn_i)                pes_q <= 1'b0;
      else if (rst_done || req_pes) pes_q <= 1'b1;
      if (!conn_i || req_prs)     pss_q <= 1'b0;
      else if (req_pss)           pss_q <= 1'b1;
      if (!conn_i) begin
        prs_q <= 1'b0;
        cnt_q <= '0;
      end else if (req_prs) begin
        prs_q <= 1'b1;
        cnt_q <= '0;
      end else if (rst_done) begin
        prs_q <= 1'b0;
      end else if (prs_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (clr_pwr_i)    pps_q <= 1'b0;
      else if (req_pps) pps_q <= 1'b1;
    end
  end

  always_comb begin
    word_o                    = '0;
    word_o[B_CCS]             = ccs_q;
    word_o[B_PES]             = pes_q;
    word_o[B_PSS]             = pss_q;
    word_o[B_POCI]            = poci_q;
    word_o[B_PRS]             = prs_q;
    word_o[B_PPS]             = pps_q;
    word_o[B_LSDA]            = lsda_q;
    word_o[HALF_W +: NCHG]    = chg_q;
  end

  assign pes_o = pes_q;
  assign pss_o = pss_q;
  assign prs_o = prs_q;
  assign pps_o = pps_q;
endmodule

// File: rtl/rh_port_bank.sv
module rh_port_bank
  import rh_pkg::*;
#(
  parameter int NPORTS     = 2,
  parameter int RST_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              xfer_busy,
  input  logic              pwr_per_port,
  input  logic [NPORTS-1:0] ppc_mask,
  input  logic              oc_per_port,
  input  logic              oc_global,
  input  logic [NPORTS-1:0] conn_i,
  input  logic [NPORTS-1:0] ls_i,
  input  logic [NPORTS-1:0] oc_i,
  output logic [NPORTS-1:0] port_power,
  output logic [NPORTS-1:0] port_enable,
  output logic [NPORTS-1:0] port_suspend,
  output logic [NPORTS-1:0] port_reset
);
  logic [DATA_W-1:0] word [NPORTS];
  logic              hub_clr;
  logic [DATA_W-1:0] rd_sel;

  assign hub_clr = cmd_valid && (cmd_code == WR_HUB) && cmd_wdata[0];

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic wr_p, clr_p;
    assign wr_p  = cmd_valid && (cmd_code == CODE_W'(WR_HUB + 1 + p));
    assign clr_p = hub_clr && (!pwr_per_port || !ppc_mask[p]);
    rh_port_ch #(.RST_CYCLES(RST_CYCLES)) u_ch (
      .clk(clk), .rst(rst), .wr_en_i(wr_p), .wdata_i(cmd_wdata),
      .busy_i(xfer_busy), .clr_pwr_i(clr_p), .oc_pp_mode_i(oc_per_port),
      .conn_i(conn_i[p]), .ls_i(ls_i[p]), .oc_i(oc_i[p]),
      .word_o(word[p]), .pes_o(port_enable[p]), .pss_o(port_suspend[p]),
      .prs_o(port_reset[p]), .pps_o(port_power[p])
    );
  end

  always_comb begin
    rd_sel = '0;
    if (cmd_code == RD_HUB) rd_sel[1] = oc_global && !oc_per_port;
    for (int p = 0; p < NPORTS; p++)
      if (cmd_code == CODE_W'(RD_HUB + 1 + p)) rd_sel = word[p];
  end

  always_ff @(posedge clk) begin
    if (rst)                            rdata <= '0;
    else if (cmd_valid && !cmd_code[7]) rdata <= rd_sel;
  end
endmodule

// File: rtl/rh_port_bank_chk.sv
module rh_port_bank_chk
  import rh_pkg::*;
#(
  parameter int NPORTS = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [CODE_W-1:0] cmd_code,
  input logic [DATA_W-1:0] cmd_wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              xfer_busy,
  input logic              pwr_per_port,
  input logic [NPORTS-1:0] ppc_mask,
  input logic [NPORTS-1:0] conn_i,
  input logic [NPORTS-1:0] port_power,
  input logic [NPORTS-1:0] port_enable,
  input logic [NPORTS-1:0] port_suspend
);
  AST_HUB_BIT0_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == RD_HUB) |=> (rdata[0] == 1'b0)); // R9
  AST_BUSY_HOLDS_REQ: assert property (@(posedge clk) disable iff (rst)
    xfer_busy |=> (((port_power & ~$past(port_power)) | (port_suspend & ~$past(port_suspend))) == '0)); // R7
  AST_SUSP_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    ((port_suspend & ~port_enable) == '0)); // R5
  AST_GLOBAL_PWR_OFF: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == WR_HUB && cmd_wdata[0] && !pwr_per_port) |=> (port_power == '0)); // R9
  AST_MASKED_PWR_OFF: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == WR_HUB && cmd_wdata[0] && pwr_per_port)
      |=> ((port_power & ~$past(ppc_mask)) == '0)); // R10
  AST_DISC_DROPS_EN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst)) |-> ((port_enable & ~$past(conn_i)) == '0)); // R12
endmodule

bind rh_port_bank rh_port_bank_chk #(.NPORTS(NPORTS)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .cmd_wdata(cmd_wdata), .rdata(rdata), .xfer_busy(xfer_busy),
  .pwr_per_port(pwr_per_port), .ppc_mask(ppc_mask), .conn_i(conn_i),
  .port_power(port_power), .port_enable(port_enable), .port_suspend(port_suspend)
);

// File: tb/rh_port_bank_tb_top.sv
module rh_port_bank_tb_top;
  localparam int NP = 2;
  localparam int TB_RST = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_code = '0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] rdata;
  logic xfer_busy = 1'b0, pwr_per_port = 1'b0, oc_per_port = 1'b0, oc_global = 1'b0;
  logic [NP-1:0] ppc_mask = '0, conn_i = '0, ls_i = '0, oc_i = '0;
  logic [NP-1:0] port_power, port_enable, port_suspend, port_reset;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  rh_port_bank #(.NPORTS(NP), .RST_CYCLES(TB_RST)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_wdata(cmd_wdata), .rdata(rdata), .xfer_busy(xfer_busy),
    .pwr_per_port(pwr_per_port), .ppc_mask(ppc_mask), .oc_per_port(oc_per_port),
    .oc_global(oc_global), .conn_i(conn_i), .ls_i(ls_i), .oc_i(oc_i),
    .port_power(port_power), .port_enable(port_enable),
    .port_suspend(port_suspend), .port_reset(port_reset)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] code, output logic [31:0] d);
    @(negedge clk); cmd_valid = 1'b1; cmd_code = code;
    @(negedge clk); cmd_valid = 1'b0; d = rdata;
  endtask

  task automatic wr(input logic [7:0] code, input logic [31:0] d);
    @(negedge clk); cmd_valid = 1'b1; cmd_code = code; cmd_wdata = d;
    @(negedge clk); cmd_valid = 1'b0; cmd_wdata = '0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h14, d); chk("R1 hub", d, 0);
    rd(8'h15, d); chk("R1 port0", d, 0);
    rd(8'h16, d); chk("R1 port1", d, 0);
    chk("R1 outputs", {port_power, port_enable, port_suspend, port_reset}, 0);
  endtask

  task automatic t_connect();
    logic [31:0] d;
    @(negedge clk); conn_i[0] = 1'b1; ls_i[0] = 1'b1;
    rd(8'h15, d); chk("R2 R3 connect low-speed", d, 32'h0001_0201);
    rd(8'h16, d); chk("R3 other port idle", d, 0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(8'h95, 32'h0); rd(8'h15, d); chk("R4 write zero keeps flag", d, 32'h0001_0201);
    wr(8'h95, 32'h0001_0000); rd(8'h15, d); chk("R4 write one clears", d, 32'h0000_0201);
  endtask

  task automatic t_setreq();
    logic [31:0] d;
    wr(8'h96, 32'h2); rd(8'h16, d); chk("R5 enable needs connect", d, 0);
    wr(8'h95, 32'h0000_0106); rd(8'h15, d); chk("R5 power+enable, no suspend", d, 32'h0000_0303);
    chk("R5 outputs", {port_power, port_enable, port_suspend}, 6'b01_01_00);
    wr(8'h95, 32'h4); rd(8'h15, d); chk("R5 suspend", d, 32'h0000_0307);
    chk("R5 suspend out", port_suspend, 2'b01);
  endtask

  task automatic t_port_reset();
    logic [31:0] d;
    wr(8'h95, 32'h10); rd(8'h15, d); chk("R6 reset running", d, 32'h0004_0313);
    chk("R6 reset out", {port_reset, port_suspend}, 4'b01_00);
    repeat (TB_RST + 2) @(negedge clk);
    rd(8'h15, d); chk("R6 reset done", d, 32'h0014_0303);
    chk("R6 reset out low", port_reset, 0);
    wr(8'h95, 32'h0014_0000); rd(8'h15, d); chk("R4 clear two flags", d, 32'h0000_0303);
  endtask

  task automatic t_defer();
    logic [31:0] d;
    @(negedge clk); conn_i[1] = 1'b1;
    wr(8'h96, 32'h0001_0000);
    @(negedge clk); xfer_busy = 1'b1;
    wr(8'h96, 32'h100);
    wr(8'h96, 32'h2);
    repeat (3) @(negedge clk);
    chk("R7 held while busy", {port_power[1], port_enable[1]}, 2'b00);
    xfer_busy = 1'b0;
    @(negedge clk);
    chk("R8 merged applied", {port_power[1], port_enable[1]}, 2'b11);
    rd(8'h16, d); chk("R7 R8 port1 word", d, 32'h0000_0103);
  endtask

  task automatic t_power();
    logic [31:0] d;
    pwr_per_port = 1'b0;
    wr(8'h94, 32'h1); chk("R9 global clear", port_power, 2'b00);
    rd(8'h14, d); chk("R9 hub bit0 reads 0", d, 0);
    wr(8'h95, 32'h100); wr(8'h96, 32'h100); chk("R5 repower", port_power, 2'b11);
    pwr_per_port = 1'b1; ppc_mask = 2'b10;
    wr(8'h94, 32'h0); chk("R10 write zero", port_power, 2'b11);
    wr(8'h94, 32'h1); chk("R10 masked clear", port_power, 2'b10);
  endtask

  task automatic t_oc();
    logic [31:0] d;
    oc_global = 1'b1; oc_per_port = 1'b0;
    rd(8'h14, d); chk("R11 global oc", d, 32'h2);
    oc_per_port = 1'b1;
    rd(8'h14, d); chk("R11 per-port hides global", d, 0);
    @(negedge clk); oc_i[0] = 1'b1;
    rd(8'h15, d); chk("R11 port oc and flag", d, 32'h0008_020B);
    @(negedge clk); oc_i[0] = 1'b0;
    wr(8'h95, 32'h0008_0000); rd(8'h15, d); chk("R11 oc cleared", d, 32'h0000_0203);
  endtask

  task automatic t_disc();
    logic [31:0] d;
    @(negedge clk); conn_i[0] = 1'b0;
    rd(8'h15, d); chk("R12 disconnect word", d, 32'h0003_0000);
    chk("R12 enable dropped", port_enable, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_connect();
    t_w1c();
    t_setreq();
    t_port_reset();
    t_defer();
    t_power();
    t_oc();
    t_disc();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule